// File: doc/BRIEF.md
# Byte-Serial SPI Master with Register Port

This block is a single-lane SPI master that a processor drives through four 32-bit word registers on a simple write-strobe bus with combinational read data. Software picks the clock polarity, the clock phase and a 5-bit rate code in the configuration word. It asserts one or more chip-select lines through the control word. It then writes a byte to the transmit word. That write starts one full-duplex 8-bit exchange: the byte goes out MSB first on MOSI while eight MISO bits are gathered, also MSB first.

Software polls a ready flag in the control word until it returns high, then reads the captured byte from the receive word. A flush request bit in the configuration word aborts any exchange in flight, returns the serial clock to its idle level and wipes the receive byte. The hardware clears the request bit on its own, so software can poll it back to zero.

Top module: `spim_legacy_top`

## Requirements
- R1: After reset the control word (byte offset 0x0) reads 0x0000_0002, the configuration word (offset 0x4) reads 0, every chip-select pin is high and SCLK is low.
- R2: Control bits 19:16 are read/write chip-select enables. Setting bit 16+n drives `spi_cs_n[n]` low. Control bit 1 is the read-only ready flag, and all other control bits read 0.
- R3: A write to the transmit word (offset 0x8) while ready is high starts an exchange using wdata[7:0]. Afterwards the receive word (offset 0xC) reads the eight MISO bits, first bit in bit 7, with bits 31:8 zero. The receive word does not change while the block is idle.
- R4: Ready reads low from the cycle after an accepted transmit write. It stays low for 16·H input clocks when phase is 0 and 17·H when phase is 1, where H is the SCLK half-period.
- R5: The rate code is configuration bits 4:0. Codes below 16 give divisor D = code, and codes 16 to 31 give D = 2·(code−16). The half-period is H = max(1, floor(D/2)) input clocks.
- R6: Configuration bit 7 is polarity. Whenever ready is high, SCLK equals this bit.
- R7: Configuration bit 6 is phase. With phase 0, MOSI holds the first bit before the first SCLK edge, both sides sample on leading edges and MOSI changes on trailing edges. With phase 1, MOSI changes on leading edges and both sides sample on trailing edges.
- R8: A transmit write made while ready is low is ignored. The exchange in progress completes with its original byte.
- R9: Writing configuration bit 9 as 1 aborts any exchange. Within two cycles bit 9 reads 0 again, ready is high, SCLK is at its idle level and the receive word reads 0.
- R10: Configuration bits 5 and 17 ignore writes and read 0. Only single-byte, non-queued operation exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Byte address; bits 3:2 pick the word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed word (combinational) |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 4 | Active-low chip selects |

## Verification
The properties assume that the bus writes at most one word per cycle. They also assume that software does not change polarity or phase while an exchange is running, because SCLK follows the polarity bit combinationally. The bench respects both assumptions: it changes the configuration only while ready reads high, and it raises the flush request only with the same mode bits already in force. Its slave model changes MISO only on SCLK edges where the master does not sample, and it keeps its chip select asserted only around complete exchanges.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int REG_W         = 32;
  localparam int CTRL_RDY_BIT  = 1;
  localparam int CTRL_CS_LSB   = 16;
  localparam int CFG_CPHA_BIT  = 6;
  localparam int CFG_CPOL_BIT  = 7;
  localparam int CFG_FLUSH_BIT = 9;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_CFG  = 2'd1,
    SEL_TX   = 2'd2,
    SEL_RX   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/spim_regs.sv
module spim_regs
  import spim_pkg::*;
#(
  parameter int CS_NUM = 4,
  parameter int PS_W   = 5,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              busy,
  input  logic [DATA_W-1:0] rx_byte,
  output logic [REG_W-1:0]  reg_rdata,
  output logic [CS_NUM-1:0] cs_en,
  output logic [PS_W-1:0]   ps_code,
  output logic              cpol,
  output logic              cpha,
  output logic              flush,
  output logic              start,
  output logic [DATA_W-1:0] tx_byte,
  output logic              ready
);
  localparam int SEL_LSB = ADDR_W - 2;

  reg_sel_e          sel;
  logic              wr_ctrl, wr_cfg;
  logic [CS_NUM-1:0] cs_en_d;
  logic [PS_W-1:0]   ps_d;
  logic              cpol_d, cpha_d, flush_d;

  assign sel     = reg_sel_e'(reg_addr[SEL_LSB +: 2]);
  assign wr_ctrl = reg_wr && (sel == SEL_CTRL);
  assign wr_cfg  = reg_wr && (sel == SEL_CFG);
  assign ready   = !busy && !flush;
  assign start   = reg_wr && (sel == SEL_TX) && ready;
  assign tx_byte = reg_wdata[DATA_W-1:0];

  always_comb begin
    cs_en_d = cs_en;
    ps_d    = ps_code;
    cpol_d  = cpol;
    cpha_d  = cpha;
    flush_d = 1'b0;
    if (wr_ctrl) cs_en_d = reg_wdata[CTRL_CS_LSB +: CS_NUM];
    if (wr_cfg) begin
      ps_d    = reg_wdata[PS_W-1:0];
      cpol_d  = reg_wdata[CFG_CPOL_BIT];
      cpha_d  = reg_wdata[CFG_CPHA_BIT];
      flush_d = reg_wdata[CFG_FLUSH_BIT] && !flush;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_en   <= '0;
      ps_code <= '0;
      cpol    <= 1'b0;
      cpha    <= 1'b0;
      flush   <= 1'b0;
    end else begin
      if (wr_ctrl) cs_en <= cs_en_d;
      if (wr_cfg) begin
        ps_code <= ps_d;
        cpol    <= cpol_d;
        cpha    <= cpha_d;
      end
      flush <= flush_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (sel)
      SEL_CTRL: begin
        reg_rdata[CTRL_CS_LSB +: CS_NUM] = cs_en;
        reg_rdata[CTRL_RDY_BIT]          = ready;
      end
      SEL_CFG: begin
        reg_rdata[PS_W-1:0]     = ps_code;
        reg_rdata[CFG_CPHA_BIT] = cpha;
        reg_rdata[CFG_CPOL_BIT] = cpol;
        reg_rdata[CFG_FLUSH_BIT] = flush;
      end
      SEL_TX:  reg_rdata = '0;
      SEL_RX:  reg_rdata[DATA_W-1:0] = rx_byte;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spim_edge_gen.sv
module spim_edge_gen #(
  parameter int PS_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [PS_W-1:0] code,
  output logic            tick
);
  logic [PS_W-1:0] half, raw_half, cnt_q, cnt_d;

  // Fine range halves the code; coarse range doubles the low bits then halves.
  assign raw_half = code[PS_W-1] ? {1'b0, code[PS_W-2:0]} : (code >> 1);
  assign half     = (raw_half == '0) ? PS_W'(1) : raw_half;
  assign tick     = run && (cnt_q == half - PS_W'(1));

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + PS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              flush,
  input  logic              tick,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              miso,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int EDGES = 2 * DATA_W;
  localparam int EC_W  = $clog2(EDGES + 2);

  logic [EC_W-1:0]   ecnt_q, ecnt_d, ecnt_inc, last_edge;
  logic              busy_d, sclk_q, sclk_d;
  logic [DATA_W-1:0] tx_q, tx_d, sh_q, sh_d, rx_d;
  logic              leading, sample_now, shift_now, in_clock;

  assign last_edge = cpha ? EC_W'(EDGES + 1) : EC_W'(EDGES);
  assign ecnt_inc  = ecnt_q + EC_W'(1);
  assign in_clock  = (ecnt_inc <= EC_W'(EDGES));
  assign leading   = ecnt_inc[0];
  assign sample_now = in_clock && (cpha ? !leading : leading);
  assign shift_now  = in_clock && (cpha ? (leading && ecnt_inc != EC_W'(1))
                                        : (!leading && ecnt_inc != EC_W'(EDGES)));

  always_comb begin
    busy_d = busy;
    ecnt_d = ecnt_q;
    sclk_d = sclk_q;
    tx_d   = tx_q;
    sh_d   = sh_q;
    rx_d   = rx_byte;
    if (flush) begin
      busy_d = 1'b0;
      ecnt_d = '0;
      sclk_d = 1'b0;
      sh_d   = '0;
      rx_d   = '0;
    end else if (start) begin
      busy_d = 1'b1;
      ecnt_d = '0;
      sclk_d = 1'b0;
      tx_d   = tx_byte;
    end else if (busy && tick) begin
      ecnt_d = ecnt_inc;
      if (in_clock)   sclk_d = !sclk_q;
      if (sample_now) sh_d   = {sh_q[DATA_W-2:0], miso};
      if (shift_now)  tx_d   = {tx_q[DATA_W-2:0], 1'b0};
      if (ecnt_inc == last_edge) begin
        busy_d = 1'b0;
        rx_d   = sh_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      ecnt_q  <= '0;
      sclk_q  <= 1'b0;
      tx_q    <= '0;
      sh_q    <= '0;
      rx_byte <= '0;
    end else begin
      busy    <= busy_d;
      ecnt_q  <= ecnt_d;
      sclk_q  <= sclk_d;
      tx_q    <= tx_d;
      sh_q    <= sh_d;
      rx_byte <= rx_d;
    end
  end

  assign sclk = sclk_q ^ cpol;
  assign mosi = tx_q[DATA_W-1];
endmodule

// File: rtl/spim_legacy_top.sv
module spim_legacy_top #(
  parameter int CS_NUM = 4,
  parameter int PS_W   = 5,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [CS_NUM-1:0] spi_cs_n
);
  logic              busy_w, tick_w, cpol_w, cpha_w, flush_w, start_w, ready_w;
  logic [CS_NUM-1:0] cs_en_w;
  logic [PS_W-1:0]   ps_w;
  logic [DATA_W-1:0] tx_w, rx_w;

  spim_regs #(.CS_NUM(CS_NUM), .PS_W(PS_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .busy(busy_w), .rx_byte(rx_w), .reg_rdata(reg_rdata),
    .cs_en(cs_en_w), .ps_code(ps_w), .cpol(cpol_w), .cpha(cpha_w),
    .flush(flush_w), .start(start_w), .tx_byte(tx_w), .ready(ready_w)
  );

  spim_edge_gen #(.PS_W(PS_W)) edge_i (
    .clk(clk), .rst_n(rst_n), .run(busy_w), .code(ps_w), .tick(tick_w)
  );

  spim_shifter #(.DATA_W(DATA_W)) shift_i (
    .clk(clk), .rst_n(rst_n), .start(start_w), .tx_byte(tx_w), .flush(flush_w),
    .tick(tick_w), .cpol(cpol_w), .cpha(cpha_w), .miso(spi_miso),
    .busy(busy_w), .sclk(spi_sclk), .mosi(spi_mosi), .rx_byte(rx_w)
  );

  assign spi_cs_n = ~cs_en_w;
endmodule

// File: rtl/spim_legacy_chk.sv
module spim_legacy_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              ready,
  input logic              flush,
  input logic              sclk,
  input logic              cpol,
  input logic [DATA_W-1:0] rx_byte
);
  logic tx_wr;
  assign tx_wr = reg_wr && (reg_addr[ADDR_W-1 -: 2] == 2'd2);

  assert_ready_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && ready) |=> !ready);

  assert_flush_self_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !flush);

  assert_flush_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> ready);

  assert_idle_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (sclk == cpol));

  assert_rx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !tx_wr && !flush) |=> $stable(rx_byte));
endmodule

bind spim_legacy_top spim_legacy_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .ready(ready_w), .flush(flush_w), .sclk(spi_sclk), .cpol(cpol_w), .rx_byte(rx_w)
);

// File: tb/spim_legacy_top_tb.sv
module spim_legacy_top_tb_top;
  logic        clk, rst_n, reg_wr, miso;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        sclk, mosi;
  logic [3:0]  cs_n;
  int n_chk = 0, n_fail = 0;

  spim_legacy_top dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(sclk),
    .spi_mosi(mosi), .spi_miso(miso), .spi_cs_n(cs_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Slave model: {cpol, cpha, code[4:0], master byte, slave byte}
  logic [7:0] sl_tx, sl_rx;
  logic       tb_cpol, tb_cpha;
  int         lead_n;
  assign miso = sl_tx[7];

  always @(sclk) begin
    if (!cs_n[0]) begin
      if (sclk != tb_cpol) begin
        if (tb_cpha) begin
          if (lead_n != 0) sl_tx = {sl_tx[6:0], 1'b0};
        end else sl_rx = {sl_rx[6:0], mosi};
        lead_n = lead_n + 1;
      end else begin
        if (tb_cpha) sl_rx = {sl_rx[6:0], mosi};
        else         sl_tx = {sl_tx[6:0], 1'b0};
      end
    end
  end

  localparam logic [22:0] VEC [8] = '{
    {1'b0, 1'b0, 5'd3,  8'hA5, 8'h3C},
    {1'b0, 1'b1, 5'd4,  8'h81, 8'h7E},
    {1'b1, 1'b0, 5'd15, 8'hC3, 8'h96},
    {1'b1, 1'b1, 5'd20, 8'h0F, 8'hF0},
    {1'b0, 1'b0, 5'd0,  8'hFF, 8'h00},
    {1'b1, 1'b1, 5'd31, 8'h00, 8'hFF},
    {1'b0, 1'b1, 5'd16, 8'h6B, 8'hD2},
    {1'b1, 1'b0, 5'd1,  8'h12, 8'hEF}
  };

  function automatic int half_of(input int code);
    int d;
    d = (code < 16) ? code : 2 * (code - 16);
    return (d / 2 < 1) ? 1 : d / 2;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 4'h0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
    reg_addr = 4'h0;
    #1;
  endtask

  task automatic wait_ready(output int c);
    c = 0;
    reg_addr = 4'h0;
    #1;
    while (!reg_rdata[1] && c < 5000) begin
      c++;
      @(negedge clk);
      #1;
    end
  endtask

  task automatic set_mode(input logic pol, input logic pha, input logic [4:0] code);
    tb_cpol = pol; tb_cpha = pha;
    wr(4'h4, (32'(pol) << 7) | (32'(pha) << 6) | 32'(code));
  endtask

  initial begin
    #3_000_000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int c;
    reg_wr = 0; reg_addr = 0; reg_wdata = 0; rst_n = 0;
    sl_tx = 0; sl_rx = 0; tb_cpol = 0; tb_cpha = 0; lead_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(4'h0, r); chk("R1 ctrl", r, 32'h0000_0002);
    rd(4'h4, r); chk("R1 cfg", r, 32'h0);
    chk("R1 cs_n", {28'h0, cs_n}, 32'hF);
    chk("R1 sclk", {31'h0, sclk}, 32'h0);

    // R2 / R10 register fields
    wr(4'h0, 32'h000F_0003);
    rd(4'h0, r); chk("R2 ctrl readback", r, 32'h000F_0002);
    chk("R2 cs_n all low", {28'h0, cs_n}, 32'h0);
    wr(4'h0, 32'h0);
    wr(4'h4, 32'h0002_0027);
    rd(4'h4, r); chk("R10 cfg bits 5 and 17", r, 32'h0000_0007);

    // Vector table: R3 R4 R5 R6 R7
    for (int i = 0; i < 8; i++) begin
      logic pol, pha;
      logic [4:0] code;
      logic [7:0] mb, sb;
      {pol, pha, code, mb, sb} = VEC[i];
      set_mode(pol, pha, code);
      chk("R6 idle level", {31'h0, sclk}, {31'h0, pol});
      sl_tx = sb; sl_rx = 8'h0; lead_n = 0;
      wr(4'h0, 32'h0001_0000);
      chk("R2 cs0 asserted", {28'h0, cs_n}, 32'hE);
      wr(4'h8, {24'hABCDEF, mb});
      wait_ready(c);
      chk("R4 R5 busy cycles", 32'(c), 32'((pha ? 17 : 16) * half_of(code)));
      rd(4'hC, r); chk("R3 R7 receive word", r, {24'h0, sb});
      chk("R7 slave got byte", {24'h0, sl_rx}, {24'h0, mb});
      chk("R6 idle after", {31'h0, sclk}, {31'h0, pol});
      wr(4'h0, 32'h0);
    end

    // R8 write while busy is ignored
    set_mode(1'b0, 1'b0, 5'd8);
    sl_tx = 8'h33; sl_rx = 0; lead_n = 0;
    wr(4'h0, 32'h0001_0000);
    wr(4'h8, 32'h5A);
    repeat (3) @(negedge clk);
    wr(4'h8, 32'hFF);
    wait_ready(c);
    chk("R8 original byte sent", {24'h0, sl_rx}, 32'h5A);
    rd(4'hC, r); chk("R8 receive word", r, 32'h33);
    wr(4'h0, 32'h0);

    // R9 flush mid-transfer
    set_mode(1'b1, 1'b0, 5'd31);
    sl_tx = 8'hC7; lead_n = 0;
    wr(4'h8, 32'h99);
    repeat (20) @(negedge clk);
    wr(4'h4, 32'h0000_029F);
    @(negedge clk);
    rd(4'h4, r); chk("R9 flush bit cleared", r, 32'h0000_009F);
    rd(4'h0, r); chk("R9 ready after flush", r & 32'h2, 32'h2);
    chk("R9 sclk idle", {31'h0, sclk}, 32'h1);
    rd(4'hC, r); chk("R9 receive cleared", r, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule